// File: doc/BRIEF.md
# Dual-Edge Strobe Read Capture

This block receives a source-synchronous read burst from a disk-style device. During the burst the device drives both a 16-bit data bus and a strobe. A fresh word is valid at every strobe transition, rising and falling alike, so each strobe period delivers two words. The strobe may arrive on an ordinary pin, so the block does not use it as a clock. Instead a fast system clock oversamples the strobe and the data through two-stage synchronizers. Any change in the synchronized strobe level counts as one capture event, and the data word synchronized alongside it is taken.

Captured words enter an 8-entry FIFO in strict arrival order and leave on a valid/ready stream. Back-pressure rules: a word is presented while `out_valid_o` is high. It is consumed on a clock edge where `out_ready_i` is also high. While valid is high and ready is low, the word and valid are held unchanged. A word captured while the FIFO is full is dropped, and a sticky overflow flag is raised.

A one-cycle `burst_start_i` pulse flushes the FIFO, clears the overflow flag, sets the reference strobe level to low and enables capture. A `burst_end_i` pulse disables capture. Capture events in that same cycle are still stored. The system clock must run at least four times faster than the strobe toggle rate, with data stable for two system clocks on each side of every strobe transition.

Top module: `dual_edge_capture`

## Requirements
- R1: After reset `out_valid_o` and `overflow_o` are 0. Strobe transitions before the first `burst_start_i` pulse store no words.
- R2: While capture is enabled, each rising and each falling transition of `dev_strobe_i` stores exactly one word: the value of `dev_data_i` present at that transition.
- R3: Words leave on `out_data_o` in the order their strobe transitions arrived, with no separation of rising-edge and falling-edge words.
- R4: `burst_start_i` empties the FIFO, clears `overflow_o` and sets the reference strobe level to low. In the cycle after the pulse `out_valid_o` and `overflow_o` are 0. If the strobe is already high at that time, one word (the current data) is captured as a rising transition.
- R5: After a `burst_end_i` pulse, further strobe transitions store no words until the next `burst_start_i`. Words captured earlier remain readable.
- R6: A word is removed on a clock edge where `out_valid_o` and `out_ready_i` are both 1. While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o` stays 1 and `out_data_o` does not change.
- R7: A capture event that occurs while the FIFO holds 8 words drops the word and sets `overflow_o`, even if a word is read in that cycle. `overflow_o` stays 1 until `burst_start_i`. The stored words are unaffected.
- R8: The FIFO holds 8 words without overflow, and its occupancy never exceeds 8.
- R9: A change of `dev_data_i` with no strobe transition stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the strobe toggle rate |
| rst_ni | input | 1 | Active-low synchronous reset |
| burst_start_i | input | 1 | One-cycle pulse: flush, clear overflow, reference level low, enable capture |
| burst_end_i | input | 1 | One-cycle pulse: disable capture after the current cycle |
| dev_strobe_i | input | 1 | Device strobe, asynchronous to clk_i |
| dev_data_i | input | 16 | Device data bus, valid at each strobe transition |
| out_valid_o | output | 1 | A captured word is presented |
| out_ready_i | input | 1 | Consumer accepts the presented word |
| out_data_o | output | 16 | Oldest captured word |
| overflow_o | output | 1 | Sticky: a word was dropped because the FIFO was full |

## Verification
On every cycle, the assertions check that a stalled word stays put, that overflow is sticky and rises only when the FIFO is full, that a burst start leaves the output empty and the flag clear, and that occupancy stays within depth. The bench's scenarios alone can show several behaviours:
- that both strobe polarities deliver the word present at their transition, in arrival order;
- that idle and post-end transitions and data-only changes store nothing;
- that a high strobe at burst start yields one word;
- that exactly the first eight words survive an overflow.

// File: rtl/dec_pkg.sv
package dec_pkg;
  typedef enum logic {
    CAP_IDLE = 1'b0,
    CAP_RUN  = 1'b1
  } cap_state_e;
endpackage

// File: rtl/dec_sync.sv
// Multi-stage synchronizer for the strobe and the data bus; equal depth keeps them aligned.
module dec_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         strobe_i,
  input  logic [W-1:0] data_i,
  output logic         strobe_o,
  output logic [W-1:0] data_o
);
  logic [STAGES-1:0] stb_q;
  logic [W-1:0]      dat_q [STAGES];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      stb_q <= '0;
      for (int i = 0; i < STAGES; i++) dat_q[i] <= '0;
    end else begin
      stb_q <= {stb_q[STAGES-2:0], strobe_i};
      dat_q[0] <= data_i;
      for (int i = 1; i < STAGES; i++) dat_q[i] <= dat_q[i-1];
    end
  end

  assign strobe_o = stb_q[STAGES-1];
  assign data_o   = dat_q[STAGES-1];
endmodule

// File: rtl/dec_ctrl.sv
// Burst framing and level-change detection on the synchronized strobe.
module dec_ctrl #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         end_i,
  input  logic         strobe_s_i,
  input  logic [W-1:0] data_s_i,
  input  logic         full_i,
  output logic         wr_en_o,
  output logic [W-1:0] wr_data_o,
  output logic         flush_o,
  output logic         overflow_o
);
  import dec_pkg::*;

  cap_state_e state_q;
  logic       ref_lvl_q;
  logic       ovf_q;
  logic       cap_evt;

  assign cap_evt   = (state_q == CAP_RUN) && (strobe_s_i != ref_lvl_q) && !start_i;
  assign wr_en_o   = cap_evt && !full_i;
  assign wr_data_o = data_s_i;
  assign flush_o   = start_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q   <= CAP_IDLE;
      ref_lvl_q <= 1'b0;
      ovf_q     <= 1'b0;
    end else if (start_i) begin
      state_q   <= CAP_RUN;
      ref_lvl_q <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      if (state_q == CAP_RUN) ref_lvl_q <= strobe_s_i;
      if (cap_evt && full_i)  ovf_q     <= 1'b1;
      if (end_i)              state_q   <= CAP_IDLE;
    end
  end

  assign overflow_o = ovf_q;
endmodule

// File: rtl/dec_fifo.sv
// Word FIFO with a flush; DEPTH must be a power of two.
module dec_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          rd_ready_i,
  output logic          rd_valid_o,
  output logic [W-1:0]  rd_data_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [CW-1:0] wr_ptr_q, rd_ptr_q;
  logic          push, pop;

  assign count_o    = wr_ptr_q - rd_ptr_q;
  assign full_o     = (count_o == CW'(DEPTH));
  assign rd_valid_o = (count_o != '0);
  assign rd_data_o  = mem_q[rd_ptr_q[AW-1:0]];
  assign push       = wr_en_i && !full_o;
  assign pop        = rd_ready_i && rd_valid_o;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_ptr_q[AW-1:0]] <= wr_data_i;
  end
endmodule

// File: rtl/dual_edge_capture.sv
module dual_edge_capture #(
  parameter int W           = 16,
  parameter int DEPTH       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = $clog2(DEPTH) + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         burst_start_i,
  input  logic         burst_end_i,
  input  logic         dev_strobe_i,
  input  logic [W-1:0] dev_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o,
  output logic         overflow_o
);
  logic          strobe_s;
  logic [W-1:0]  data_s;
  logic          wr_en_w;
  logic [W-1:0]  wr_data_w;
  logic          flush_w;
  logic          fifo_full_w;
  logic [CW-1:0] fifo_count_w;

  dec_sync #(.W(W), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (dev_strobe_i),
    .data_i   (dev_data_i),
    .strobe_o (strobe_s),
    .data_o   (data_s)
  );

  dec_ctrl #(.W(W)) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (burst_start_i),
    .end_i      (burst_end_i),
    .strobe_s_i (strobe_s),
    .data_s_i   (data_s),
    .full_i     (fifo_full_w),
    .wr_en_o    (wr_en_w),
    .wr_data_o  (wr_data_w),
    .flush_o    (flush_w),
    .overflow_o (overflow_o)
  );

  dec_fifo #(.W(W), .DEPTH(DEPTH)) fifo_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_w),
    .wr_en_i    (wr_en_w),
    .wr_data_i  (wr_data_w),
    .rd_ready_i (out_ready_i),
    .rd_valid_o (out_valid_o),
    .rd_data_o  (out_data_o),
    .full_o     (fifo_full_w),
    .count_o    (fifo_count_w)
  );
endmodule

// File: rtl/dec_checker.sv
module dec_checker #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          burst_start_i,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [W-1:0]  out_data_o,
  input logic          overflow_o,
  input logic          fifo_full,
  input logic [CW-1:0] fifo_count
);
  // R6
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && !burst_start_i) |=> (out_valid_o && $stable(out_data_o)));

  // R7
  overflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !burst_start_i) |=> overflow_o);

  // R7
  overflow_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(fifo_full));

  // R4
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_start_i |=> (!out_valid_o && !overflow_o));

  // R8
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_count <= CW'(DEPTH));
endmodule

bind dual_edge_capture dec_checker #(.W(W), .DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .burst_start_i (burst_start_i),
  .out_valid_o   (out_valid_o),
  .out_ready_i   (out_ready_i),
  .out_data_o    (out_data_o),
  .overflow_o    (overflow_o),
  .fifo_full     (fifo_full_w),
  .fifo_count    (fifo_count_w)
);

// File: tb/dual_edge_capture_tb_top.sv
`timescale 1ns/1ps
module dual_edge_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        stop = 1'b0;
  logic        strobe = 1'b0;
  logic [15:0] data = '0;
  logic        valid;
  logic        ready = 1'b0;
  logic [15:0] dout;
  logic        ovf;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  dual_edge_capture dut_i (
    .clk_i(clk), .rst_ni(rst_n), .burst_start_i(start), .burst_end_i(stop),
    .dev_strobe_i(strobe), .dev_data_i(data), .out_valid_o(valid),
    .out_ready_i(ready), .out_data_o(dout), .overflow_o(ovf)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one word per strobe transition: data settles 2 clocks before, holds 2 after
  task automatic send_word(input logic [15:0] d);
    @(negedge clk); data = d;
    wait_clks(2); strobe = ~strobe;
    wait_clks(2);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pop_expect(input logic [15:0] exp, input string req);
    int n = 0;
    @(negedge clk);
    while (!valid && n < 50) begin @(negedge clk); n++; end
    chk(valid == 1'b1, req, "valid before pop", 32'(valid), 32'd1);
    chk(dout == exp, req, "popped word", 32'(dout), 32'(exp));
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
  endtask

  task automatic t_reset();
    chk(valid == 1'b0, "R1", "valid after reset", 32'(valid), 32'd0);
    chk(ovf == 1'b0, "R1", "overflow after reset", 32'(ovf), 32'd0);
  endtask

  task automatic t_idle_ignored();
    send_word(16'h0101); send_word(16'h0202); send_word(16'h0303);
    wait_clks(4);
    chk(valid == 1'b0, "R1", "idle transitions store nothing", 32'(valid), 32'd0);
  endtask

  task automatic t_start_high_and_order();
    // strobe is high here; burst start must capture the current word once
    @(negedge clk); data = 16'hA5A5;
    pulse_start();
    wait_clks(4);
    chk(valid == 1'b1, "R4", "high strobe at start captured", 32'(valid), 32'd1);
    send_word(16'h1111);   // falling
    send_word(16'h2222);   // rising
    send_word(16'h3333);   // falling
    wait_clks(4);
    pop_expect(16'hA5A5, "R4");
    pop_expect(16'h1111, "R2");
    pop_expect(16'h2222, "R2");
    pop_expect(16'h3333, "R3");
    wait_clks(2);
    chk(valid == 1'b0, "R2", "one word per transition", 32'(valid), 32'd0);
  endtask

  task automatic t_data_only();
    @(negedge clk); data = 16'hDEAD;
    wait_clks(3); data = 16'hBEEF;
    wait_clks(6);
    chk(valid == 1'b0, "R9", "data change without strobe", 32'(valid), 32'd0);
  endtask

  task automatic t_stall();
    logic [15:0] held;
    send_word(16'h4444); send_word(16'h5555);
    wait_clks(4);
    held = dout;
    chk(held == 16'h4444, "R6", "head word", 32'(held), 32'h4444);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(valid == 1'b1 && dout == held, "R6", "held while stalled", 32'(dout), 32'(held));
    end
    pop_expect(16'h4444, "R6");
    pop_expect(16'h5555, "R3");
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 8; i++) send_word(16'h8000 + 16'(i));
    wait_clks(4);
    chk(ovf == 1'b0, "R8", "eight words fit", 32'(ovf), 32'd0);
    send_word(16'hEEE0); send_word(16'hEEE1);
    wait_clks(4);
    chk(ovf == 1'b1, "R7", "overflow set when full", 32'(ovf), 32'd1);
    for (int i = 0; i < 8; i++) pop_expect(16'h8000 + 16'(i), "R7");
    wait_clks(2);
    chk(valid == 1'b0, "R7", "dropped words absent", 32'(valid), 32'd0);
    chk(ovf == 1'b1, "R7", "overflow sticky", 32'(ovf), 32'd1);
    pulse_start();
    wait_clks(2);
    chk(ovf == 1'b0, "R4", "start clears overflow", 32'(ovf), 32'd0);
  endtask

  task automatic t_end();
    send_word(16'h6666); send_word(16'h7777);
    wait_clks(4);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    send_word(16'h9999); send_word(16'hAAAA);
    wait_clks(6);
    pop_expect(16'h6666, "R5");
    pop_expect(16'h7777, "R5");
    wait_clks(2);
    chk(valid == 1'b0, "R5", "no capture after end", 32'(valid), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_clks(4);
    rst_n = 1'b1;
    wait_clks(2);
    t_reset();
    t_idle_ignored();
    t_start_high_and_order();
    t_data_only();
    t_stall();
    t_overflow();
    t_end();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule